// File: doc/BRIEF.md
# Seconds Counter RTC with Alarm Compare

This block is a real-time clock peripheral. It holds a free-running seconds count and a compare value of the same width, both reached through a small 8-bit register file. The count advances by one on each pulse of a one-second tick input, but only while the run bit of the control register is set. Software sets the time by writing the upper staging bytes first. It then writes the lowest staging byte, and that write moves the whole staged value into the counter in a single clock edge.

The current count is read byte by byte at any time. The read bytes are not frozen, so a carry between two byte reads can show up. Software detects this by reading the lowest byte a second time and comparing. When the count reaches the compare value while the alarm enable bit is set, a sticky pending flag is raised and drives the interrupt output. The flag stays set until software writes a one to the clear bit of the second alarm control register.

The bus is a simple synchronous write strobe with a combinational read port. The register offsets are fixed: control at 0, alarm control 2 at 1, staging bytes at 2 to 5, live count bytes at 6 to 9, compare bytes at 10 to 13.

Top module: `secs_rtc`

## Requirements
- R1: After reset every register reads 0, the count is 0 and `alarm_irq` is low.
- R2: Writes to staging offsets 3, 4 and 5 only store their byte: the count does not change. Offsets 2 to 5 read back the last staged bytes.
- R3: A write to offset 2 loads the counter at that clock edge with {stage byte 3, stage byte 2, stage byte 1, written data}. A load takes priority over a tick on the same edge.
- R4: While control bit 7 is 1, each clock edge with `sec_tick` high adds one to the count. The count wraps from 0xFFFFFFFF to 0.
- R5: While control bit 7 is 0, ticks leave the count unchanged.
- R6: Offsets 6 to 9 return the live count in little-endian order, with offset 6 holding bits 7:0. Reading offset 6 again after a carry returns a smaller value than before.
- R7: Offsets 10 to 13 hold the 32-bit compare value, little-endian with offset 10 holding bits 7:0, and read back as written.
- R8: When the count becomes equal to the compare value while control bit 1 is 1, the pending flag sets on the following edge and `alarm_irq` goes high. Bit 0 of offset 1 reads the pending flag.
- R9: The pending flag stays set until a write of 1 to bit 0 of offset 1. Writing 0 there has no effect. If a clear and a new match land on the same edge, the flag stays set.
- R10: While control bit 1 is 0, no new pending alarm is raised, even when the count equals the compare value.
- R11: The control register reads back all eight bits as written. Bits 7:1 of offset 1 read back as written. Offsets 14 and 15 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, high while an alarm is pending |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same edge as a fresh match. To get there, the bench loads the count to one below the compare value and issues a single tick. It then drives the clear write on the cycle when the match first appears, so the edge that sets the flag also carries the clear. The bench also covers the 0xFFFFFFFF wrap and a carry across the low byte. For the carry, it reads the lowest byte before and after one tick, which shows the smaller value that a re-read returns after a rollover.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  // fixed register offsets; the byte windows follow from the count width
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_ACTL2 = 1;
  localparam int unsigned OFS_STAGE = 2;

  // control bit positions
  localparam int unsigned RUN_BIT = 7;
  localparam int unsigned AEN_BIT = 1;
  localparam int unsigned CLR_BIT = 0;

  function automatic bit in_window(int unsigned addr, int unsigned base, int unsigned n);
    return (addr >= base) && (addr < base + n);
  endfunction
endpackage

// File: rtl/secs_rtc_regs.sv
module secs_rtc_regs
  import secs_rtc_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int AW    = 4,
  localparam int W    = BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    ctrl_q,
  output logic [7:0]    actl2_q,
  output logic [W-1:0]  stage_q,
  output logic [W-1:0]  cmp_q,
  output logic          load_pulse,
  output logic [W-1:0]  load_val,
  output logic          clear_pulse
);
  localparam int unsigned OFS_LIVE = OFS_STAGE + BYTES;
  localparam int unsigned OFS_CMP  = OFS_LIVE + BYTES;

  int unsigned a;
  assign a = int'(bus_addr);

  assign load_pulse  = bus_wr && (a == OFS_STAGE);
  assign load_val    = {stage_q[W-1:8], bus_wdata};
  assign clear_pulse = bus_wr && (a == OFS_ACTL2) && bus_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      actl2_q <= '0;
    end else if (bus_wr) begin
      if (a == OFS_CTRL)  ctrl_q  <= bus_wdata;
      if (a == OFS_ACTL2) actl2_q <= {bus_wdata[7:1], 1'b0};
    end
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_bytes
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[i*8 +: 8] <= '0;
        cmp_q[i*8 +: 8]   <= '0;
      end else if (bus_wr) begin
        if (a == OFS_STAGE + i) stage_q[i*8 +: 8] <= bus_wdata;
        if (a == OFS_CMP + i)   cmp_q[i*8 +: 8]   <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         inc_evt
);
  function automatic logic [W-1:0] next_sec(logic [W-1:0] c);
    return c + W'(1);
  endfunction

  assign inc_evt = run && tick && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (inc_evt) count <= next_sec(count);
  end
endmodule

// File: rtl/secs_rtc_alarm.sv
module secs_rtc_alarm #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp_val,
  input  logic         aen,
  input  logic         clear,
  output logic         match_rise,
  output logic         pending
);
  logic match_now, match_q;

  assign match_now  = aen && (count == cmp_val);
  assign match_rise = match_now && !match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      pending <= 1'b0;
    end else begin
      match_q <= match_now;
      if (match_rise)  pending <= 1'b1;
      else if (clear)  pending <= 1'b0;
    end
  end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          alarm_irq
);
  localparam int W = BYTES * 8;
  localparam int unsigned OFS_LIVE = OFS_STAGE + BYTES;
  localparam int unsigned OFS_CMP  = OFS_LIVE + BYTES;

  logic [7:0]   ctrl_q, actl2_q;
  logic [W-1:0] stage_q, cmp_q, load_val, count;
  logic         load_pulse, clear_pulse, inc_evt, match_rise, pending;
  logic         run, aen;

  assign run = ctrl_q[RUN_BIT];
  assign aen = ctrl_q[AEN_BIT];

  secs_rtc_regs #(.BYTES(BYTES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .actl2_q(actl2_q),
    .stage_q(stage_q), .cmp_q(cmp_q), .load_pulse(load_pulse),
    .load_val(load_val), .clear_pulse(clear_pulse)
  );

  secs_rtc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(sec_tick),
    .load(load_pulse), .load_val(load_val), .count(count), .inc_evt(inc_evt)
  );

  secs_rtc_alarm #(.W(W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .count(count), .cmp_val(cmp_q), .aen(aen),
    .clear(clear_pulse), .match_rise(match_rise), .pending(pending)
  );

  assign alarm_irq = pending;

  always_comb begin
    int unsigned a;
    a = int'(bus_addr);
    bus_rdata = '0;
    if (a == OFS_CTRL)       bus_rdata = ctrl_q;
    else if (a == OFS_ACTL2) bus_rdata = {actl2_q[7:1], pending};
    else if (in_window(a, OFS_STAGE, BYTES)) bus_rdata = stage_q[(a - OFS_STAGE)*8 +: 8];
    else if (in_window(a, OFS_LIVE, BYTES))  bus_rdata = count[(a - OFS_LIVE)*8 +: 8];
    else if (in_window(a, OFS_CMP, BYTES))   bus_rdata = cmp_q[(a - OFS_CMP)*8 +: 8];
  end
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sec_tick,
  input logic         run,
  input logic         aen,
  input logic         load_pulse,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         clear_pulse,
  input logic         match_rise,
  input logic         pending
);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> count == $past(load_val));
  assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sec_tick && !load_pulse) |=> count == W'($past(count) + W'(1)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_pulse) |=> count == $past(count));
  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_rise |=> pending);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear_pulse) |=> pending);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_pulse && !match_rise) |=> !pending);
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !aen |=> !$rose(pending));
endmodule

bind secs_rtc secs_rtc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .run(run), .aen(aen),
  .load_pulse(load_pulse), .load_val(load_val), .count(count),
  .clear_pulse(clear_pulse), .match_rise(match_rise), .pending(pending)
);

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb;
  logic clk = 0, rst_n = 0, sec_tick = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic alarm_irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  secs_rtc u_dut (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk); bus_addr = 4'(a); #1 d = bus_rdata;
  endtask

  task automatic rd32(int base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(base + i, b); v[i*8 +: 8] = b; end
  endtask

  task automatic load(logic [31:0] v);
    wr(5, v[31:24]); wr(4, v[23:16]); wr(3, v[15:8]); wr(2, v[7:0]);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1; @(negedge clk); sec_tick = 0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic [31:0] v, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state; R11 unmapped offsets read 0
    chk("R1 irq", alarm_irq, 0);
    for (int a = 0; a < 16; a++) begin rd(a, b); chk("R1 reset read", b, 0); end
    // R11 control readback, offset 1 upper bits, unmapped writes ignored
    wr(0, 8'h5C); rd(0, b); chk("R11 ctrl readback", b, 8'h5C);
    wr(1, 8'hA4); rd(1, b); chk("R11 actl2 readback", b, 8'hA4);
    wr(14, 8'hFF); wr(15, 8'h77);
    rd(14, b); chk("R11 unmapped 14", b, 0);
    rd(15, b); chk("R11 unmapped 15", b, 0);
    wr(0, 0); wr(1, 0);
    // R2 staging does not touch the count
    wr(3, 8'h11); wr(4, 8'h22); wr(5, 8'h33);
    rd32(6, v); chk("R2 count unchanged", v, 0);
    rd32(2, v); chk("R2 stage readback", v, 32'h33221100);
    // R3, R6 load sweep
    for (int k = 0; k < 16; k++) begin
      exp = 32'h01020304 * (k + 1) ^ (32'h80000001 << (k % 8));
      load(exp);
      rd32(6, v); chk("R3 R6 load and live read", v, exp);
    end
    // R5 hold while stopped
    load(32'h00000100); ticks(5);
    rd32(6, v); chk("R5 hold", v, 32'h100);
    // R4 run and carry; R6 re-read after rollover of low byte
    load(32'h000001FE); wr(0, 8'h80);
    ticks(1); rd(6, b); chk("R6 low byte before carry", b, 8'hFF);
    ticks(1); rd(6, b); chk("R6 low byte after carry", b, 8'h00);
    rd(7, b); chk("R6 byte1 after carry", b, 8'h02);
    for (int n = 1; n <= 20; n++) begin
      ticks(1); rd32(6, v); chk("R4 increment", v, 32'h200 + n);
    end
    // R4 wrap
    load(32'hFFFFFFFF); ticks(1);
    rd32(6, v); chk("R4 wrap", v, 0);
    // R3 load wins over tick
    wr(5, 8'hAB); wr(4, 8'hCD); wr(3, 8'hEF);
    @(negedge clk); bus_wr = 1; bus_addr = 2; bus_wdata = 8'h10; sec_tick = 1;
    @(negedge clk); bus_wr = 0; sec_tick = 0;
    rd32(6, v); chk("R3 load priority", v, 32'hABCDEF10);
    // R7 compare readback
    for (int i = 0; i < 4; i++) wr(10 + i, 8'h5A + i * 8'h13);
    rd32(10, v); chk("R7 compare readback", v, {8'h93, 8'h80, 8'h6D, 8'h5A});
    // R8 / R9 alarm sweep
    for (int d = 1; d <= 4; d++) begin
      exp = 32'h00345600 + 32'(d * 7);
      wr(0, 8'h80);
      for (int i = 0; i < 4; i++) wr(10 + i, exp[i*8 +: 8]);
      load(exp - 32'(d)); wr(0, 8'h82);
      ticks(d - 1); chk("R8 no early alarm", alarm_irq, 0);
      ticks(1); @(negedge clk);
      chk("R8 alarm raised", alarm_irq, 1);
      rd(1, b); chk("R8 pending bit", b[0], 1);
      wr(1, 8'h00); ticks(2); chk("R9 zero write no clear", alarm_irq, 1);
      wr(1, 8'h01); chk("R9 cleared", alarm_irq, 0);
    end
    // R10 alarm disabled
    wr(0, 8'h80); load(32'h00000FFF);
    for (int i = 0; i < 4; i++) wr(10 + i, (32'h00001000 >> (i * 8)) & 8'hFF);
    ticks(1); repeat (2) @(negedge clk);
    chk("R10 no alarm while disabled", alarm_irq, 0);
    // R9 clear and match on the same edge
    load(32'h00000FFF); wr(0, 8'h82);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h01;
    @(negedge clk); bus_wr = 0;
    chk("R9 set wins over clear", alarm_irq, 1);
    wr(1, 8'h01); chk("R9 later clear", alarm_irq, 0);
    finish_run();
  end
endmodule